// File: doc/BRIEF.md
# Rail Enable Sequencer with Voltage Fault Response

This block takes one output rail from its enable input to regulation and then watches it for output-voltage faults. When enable goes high it runs a fixed start-up wait and a programmable delay, both counted from the same moment. It then steps a digital reference code from zero up to a programmable target over a programmable number of timebase ticks. Once the ramp has finished and the sensed output lies inside its window, it reports power good.

A digitized output-voltage sample is compared against an over-voltage threshold and an under-voltage threshold. Each fault type can be switched on or off. When it is on, the fault can either latch the rail off or restart it after a hiccup interval. An over-voltage fault also toggles a low-side switch drive for as long as the sample stays above its threshold. All times are counted in ticks of a single-cycle tick-enable input. Threshold, time and target values are plain register inputs that stay static while the rail runs.

Top module: `railseq_top`

## Requirements
- R1: After reset, and on the clock edge after enable is sampled low, rail_on, pgood, alert, lsd_pulse, ov_flag and uv_flag are 0 and vref is 0. Dropping enable at any point, including mid-ramp, returns the block to idle.
- R2: After enable is asserted from idle, rail_on rises one clock after the N-th tick, where N = max(INIT_TICKS, dly_ticks).
- R3: While the rail ramps, vref after k ticks equals floor(target_code·k/ramp_ticks) and never decreases. After ramp_ticks ticks it equals target_code. With ramp_ticks = 0, vref equals target_code on the first cycle rail_on is high.
- R4: pgood is 1 only after the ramp has completed and while uv_thr ≤ vsample ≤ ov_thr. It is 0 during the wait and the ramp.
- R5: With ov_en set, a sample above ov_thr while the rail is on turns rail_on off and clears vref and pgood. It sets ov_flag and alert. lsd_pulse then toggles on every tick until the sample is no longer above ov_thr, and after that lsd_pulse is 0.
- R6: With uv_en set, a sample below uv_thr during regulation turns rail_on off and clears pgood. It sets uv_flag and alert, and lsd_pulse stays 0.
- R7: A fault type whose enable is clear causes no flag, no alert, no lsd_pulse and no change of rail_on. Only pgood drops while the sample is outside the window.
- R8: A fault in latch mode (its retry input 0) keeps rail_on low until enable is taken low and high again. The restart then follows R2.
- R9: A fault in retry mode raises rail_on again after hiccup_ticks + dly_ticks ticks, counted from the end of the fault response. The fixed start-up wait is not repeated. Flags and alert stay set.
- R10: ov_flag, uv_flag and alert stay set until enable is deasserted, and they clear on the edge after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timebase strobe, one cycle wide |
| en | input | 1 | Rail enable request |
| dly_ticks | input | TIME_W | Soft-start delay in ticks |
| ramp_ticks | input | TIME_W | Ramp duration in ticks, 0 for a step |
| hiccup_ticks | input | TIME_W | Retry wait after a fault in ticks |
| target_code | input | CODE_W | Final reference code |
| ov_thr | input | CODE_W | Over-voltage threshold |
| uv_thr | input | CODE_W | Under-voltage threshold |
| vsample | input | CODE_W | Digitized output voltage |
| ov_en | input | 1 | Over-voltage fault enable |
| uv_en | input | 1 | Under-voltage fault enable |
| ov_retry | input | 1 | 1: retry after over-voltage, 0: latch off |
| uv_retry | input | 1 | 1: retry after under-voltage, 0: latch off |
| rail_on | output | 1 | Rail enable to the modulator |
| vref | output | CODE_W | Reference code |
| pgood | output | 1 | Power good |
| alert | output | 1 | Fault alert |
| lsd_pulse | output | 1 | Low-side switch drive during over-voltage |
| ov_flag | output | 1 | Over-voltage fault seen |
| uv_flag | output | 1 | Under-voltage fault seen |

## Verification
If the sequencing state goes wrong, the tick count between enable and the rise of rail_on is off. A ramp counter that misbehaves gives a wrong vref at the mid-ramp sample or at the end of the ramp within a single tick. A broken fault path leaves rail_on or the flags wrong within three clocks of the bad sample. A wrong retry or latch decision shows as rail_on rising at the wrong tick count, or rising at all, after the fault clears. The divider that feeds the ramp step can only be seen through vref, so the vectors use targets that do not divide evenly by the ramp length.

// File: rtl/railseq_pkg.sv
package railseq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_WAIT   = 3'd1,
    ST_RAMP   = 3'd2,
    ST_REG    = 3'd3,
    ST_DRAIN  = 3'd4,
    ST_LATCH  = 3'd5,
    ST_HICCUP = 3'd6
  } rs_state_e;
endpackage

// File: rtl/railseq_div.sv
// Serial restoring divider: one quotient bit per clock, NUM_W clocks.
module railseq_div #(
  parameter int NUM_W = 12,
  parameter int DEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic [NUM_W-1:0] quo,
  output logic [DEN_W-1:0] rem,
  output logic             valid
);
  localparam int CW = $clog2(NUM_W + 1);

  logic [NUM_W-1:0] sh_q;
  logic [DEN_W:0]   r_q;
  logic [CW-1:0]    left_q;
  logic             busy_q;
  logic [DEN_W:0]   trial;

  assign trial = {r_q[DEN_W-1:0], sh_q[NUM_W-1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      r_q    <= '0;
      quo    <= '0;
      left_q <= '0;
      busy_q <= 1'b0;
      valid  <= 1'b0;
    end else if (start) begin
      sh_q   <= num;
      r_q    <= '0;
      quo    <= '0;
      left_q <= CW'(NUM_W);
      busy_q <= 1'b1;
      valid  <= 1'b0;
    end else if (busy_q) begin
      if (trial >= {1'b0, den}) begin
        r_q <= trial - {1'b0, den};
        quo <= {quo[NUM_W-2:0], 1'b1};
      end else begin
        r_q <= trial;
        quo <= {quo[NUM_W-2:0], 1'b0};
      end
      sh_q   <= sh_q << 1;
      left_q <= left_q - 1'b1;
      if (left_q == CW'(1)) begin
        busy_q <= 1'b0;
        valid  <= 1'b1;
      end
    end
  end

  assign rem = r_q[DEN_W-1:0];
endmodule

// File: rtl/railseq_ramp.sv
// Reference ramp: adds quotient each tick, plus one when the remainder accumulator wraps.
module railseq_ramp #(
  parameter int CODE_W = 12,
  parameter int TIME_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              start,
  input  logic              tick,
  input  logic [CODE_W-1:0] target,
  input  logic [TIME_W-1:0] len,
  input  logic [CODE_W-1:0] step_q,
  input  logic [TIME_W-1:0] step_r,
  output logic [CODE_W-1:0] vref,
  output logic              done
);
  logic              active_q;
  logic [TIME_W-1:0] k_q;
  logic [TIME_W-1:0] err_q;
  logic [TIME_W:0]   err_n;

  assign err_n = {1'b0, err_q} + {1'b0, step_r};

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      vref     <= '0;
      done     <= 1'b0;
      active_q <= 1'b0;
      k_q      <= '0;
      err_q    <= '0;
    end else if (start) begin
      k_q      <= '0;
      err_q    <= '0;
      done     <= (len == '0);
      active_q <= (len != '0);
      vref     <= (len == '0) ? target : '0;
    end else if (active_q && tick) begin
      k_q <= k_q + 1'b1;
      if (err_n >= {1'b0, len}) begin
        err_q <= TIME_W'(err_n - {1'b0, len});
        vref  <= vref + step_q + 1'b1;
      end else begin
        err_q <= err_n[TIME_W-1:0];
        vref  <= vref + step_q;
      end
      if ((k_q + 1'b1) == len) begin
        active_q <= 1'b0;
        done     <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/railseq_vmon.sv
// Registered digital window compare of the sensed output.
module railseq_vmon #(
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] sample,
  input  logic [CODE_W-1:0] ov_thr,
  input  logic [CODE_W-1:0] uv_thr,
  output logic              ov_hit,
  output logic              uv_hit,
  output logic              in_win
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ov_hit <= 1'b0;
      uv_hit <= 1'b0;
      in_win <= 1'b0;
    end else begin
      ov_hit <= (sample > ov_thr);
      uv_hit <= (sample < uv_thr);
      in_win <= (sample <= ov_thr) && (sample >= uv_thr);
    end
  end
endmodule

// File: rtl/railseq_top.sv
module railseq_top
  import railseq_pkg::*;
#(
  parameter int CODE_W     = 12,
  parameter int TIME_W     = 16,
  parameter int INIT_TICKS = 200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              en,
  input  logic [TIME_W-1:0] dly_ticks,
  input  logic [TIME_W-1:0] ramp_ticks,
  input  logic [TIME_W-1:0] hiccup_ticks,
  input  logic [CODE_W-1:0] target_code,
  input  logic [CODE_W-1:0] ov_thr,
  input  logic [CODE_W-1:0] uv_thr,
  input  logic [CODE_W-1:0] vsample,
  input  logic              ov_en,
  input  logic              uv_en,
  input  logic              ov_retry,
  input  logic              uv_retry,
  output logic              rail_on,
  output logic [CODE_W-1:0] vref,
  output logic              pgood,
  output logic              alert,
  output logic              lsd_pulse,
  output logic              ov_flag,
  output logic              uv_flag
);
  localparam int IW    = $clog2(INIT_TICKS + 1);
  localparam int CNT_W = ((IW > TIME_W) ? IW : TIME_W) + 1;
  localparam logic [CNT_W-1:0] INIT_C = CNT_W'(INIT_TICKS);

  rs_state_e         state_q, state_d;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  dly_c, need;
  logic              init_done_q;
  logic              ov_hit, uv_hit, in_win;
  logic              div_valid;
  logic [CODE_W-1:0] step_q;
  logic [TIME_W-1:0] step_r;
  logic              ramp_done;
  logic              ramp_start, ramp_clr, div_start;
  logic              ov_evt, uv_evt;

  railseq_vmon #(.CODE_W(CODE_W)) u_vmon (
    .clk(clk), .rst(rst), .sample(vsample), .ov_thr(ov_thr), .uv_thr(uv_thr),
    .ov_hit(ov_hit), .uv_hit(uv_hit), .in_win(in_win)
  );

  railseq_div #(.NUM_W(CODE_W), .DEN_W(TIME_W)) u_div (
    .clk(clk), .rst(rst), .start(div_start), .num(target_code), .den(ramp_ticks),
    .quo(step_q), .rem(step_r), .valid(div_valid)
  );

  railseq_ramp #(.CODE_W(CODE_W), .TIME_W(TIME_W)) u_ramp (
    .clk(clk), .rst(rst), .clr(ramp_clr), .start(ramp_start), .tick(tick),
    .target(target_code), .len(ramp_ticks), .step_q(step_q), .step_r(step_r),
    .vref(vref), .done(ramp_done)
  );

  // The start-up wait and the delay both begin at enable; the longer one governs.
  assign dly_c = CNT_W'(dly_ticks);
  assign need  = (init_done_q || dly_c > INIT_C) ? dly_c : INIT_C;

  always_comb begin
    state_d = state_q;
    ov_evt  = 1'b0;
    uv_evt  = 1'b0;
    case (state_q)
      ST_IDLE:   state_d = ST_WAIT;
      ST_WAIT:   if (cnt_q >= need && div_valid) state_d = ST_RAMP;
      ST_RAMP: begin
        if (ov_en && ov_hit) begin
          state_d = ST_DRAIN;
          ov_evt  = 1'b1;
        end else if (ramp_done) begin
          state_d = ST_REG;
        end
      end
      ST_REG: begin
        if (ov_en && ov_hit) begin
          state_d = ST_DRAIN;
          ov_evt  = 1'b1;
        end else if (uv_en && uv_hit) begin
          state_d = uv_retry ? ST_HICCUP : ST_LATCH;
          uv_evt  = 1'b1;
        end
      end
      ST_DRAIN:  if (!ov_hit) state_d = ov_retry ? ST_HICCUP : ST_LATCH;
      ST_LATCH:  state_d = ST_LATCH;
      ST_HICCUP: if (cnt_q >= CNT_W'(hiccup_ticks)) state_d = ST_WAIT;
      default:   state_d = ST_IDLE;
    endcase
    if (!en) begin
      state_d = ST_IDLE;
      ov_evt  = 1'b0;
      uv_evt  = 1'b0;
    end
  end

  assign div_start  = (state_d == ST_WAIT) && (state_q != ST_WAIT);
  assign ramp_start = (state_d == ST_RAMP) && (state_q != ST_RAMP);
  assign ramp_clr   = (state_d != ST_RAMP) && (state_d != ST_REG);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      init_done_q <= 1'b0;
      rail_on     <= 1'b0;
      pgood       <= 1'b0;
      alert       <= 1'b0;
      lsd_pulse   <= 1'b0;
      ov_flag     <= 1'b0;
      uv_flag     <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_d != state_q)
        cnt_q <= '0;
      else if (tick && (state_q == ST_WAIT || state_q == ST_HICCUP))
        cnt_q <= cnt_q + 1'b1;

      if (state_d == ST_IDLE)
        init_done_q <= 1'b0;
      else if (ramp_start)
        init_done_q <= 1'b1;

      rail_on <= (state_d == ST_RAMP) || (state_d == ST_REG);
      pgood   <= (state_d == ST_REG) && in_win;

      if (state_d == ST_DRAIN)
        lsd_pulse <= tick ? ~lsd_pulse : lsd_pulse;
      else
        lsd_pulse <= 1'b0;

      if (state_d == ST_IDLE) begin
        alert   <= 1'b0;
        ov_flag <= 1'b0;
        uv_flag <= 1'b0;
      end else begin
        alert   <= alert | ov_evt | uv_evt;
        ov_flag <= ov_flag | ov_evt;
        uv_flag <= uv_flag | uv_evt;
      end
    end
  end
endmodule

// File: rtl/railseq_chk.sv
module railseq_chk #(
  parameter int CODE_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic              rail_on,
  input logic              pgood,
  input logic              alert,
  input logic              lsd_pulse,
  input logic              ov_flag,
  input logic              uv_flag,
  input logic [CODE_W-1:0] vref,
  input logic [CODE_W-1:0] target_code
);
  p_idle_on_disable_r1: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!rail_on && !pgood && !alert && !ov_flag && !uv_flag && vref == '0));

  p_vref_monotonic_r3: assert property (@(posedge clk) disable iff (rst)
    (rail_on && $past(rail_on)) |-> (vref >= $past(vref)));

  p_vref_bound_r3: assert property (@(posedge clk) disable iff (rst)
    vref <= target_code);

  p_pgood_needs_rail_r4: assert property (@(posedge clk) disable iff (rst)
    pgood |-> rail_on);

  p_ov_shutdown_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(ov_flag) |-> (!rail_on && !pgood && alert));

  p_lsd_only_in_ov_r5: assert property (@(posedge clk) disable iff (rst)
    lsd_pulse |-> (ov_flag && !rail_on));

  p_uv_shutdown_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(uv_flag) |-> (!rail_on && !pgood && alert && !lsd_pulse));

  p_flags_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (en && $past(en) && $past(alert)) |-> alert);
endmodule

bind railseq_top railseq_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst(rst), .en(en), .rail_on(rail_on), .pgood(pgood),
  .alert(alert), .lsd_pulse(lsd_pulse), .ov_flag(ov_flag), .uv_flag(uv_flag),
  .vref(vref), .target_code(target_code)
);

// File: tb/sim_railseq_top.sv
module sim_railseq_top;
  localparam int CODE_W = 12;
  localparam int TIME_W = 16;
  localparam int INIT   = 10;
  localparam int TICKP  = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic en = 1'b0;
  logic [TIME_W-1:0] dly_ticks = 16'd3, ramp_ticks = 16'd4, hiccup_ticks = 16'd6;
  logic [CODE_W-1:0] target_code = 12'd1000, ov_thr = 12'd3000, uv_thr = 12'd500;
  logic [CODE_W-1:0] vsample = 12'd1000;
  logic ov_en = 1'b1, uv_en = 1'b1, ov_retry = 1'b0, uv_retry = 1'b0;
  logic rail_on, pgood, alert, lsd_pulse, ov_flag, uv_flag;
  logic [CODE_W-1:0] vref;

  int checks = 0;
  int errors = 0;
  int tcount = 0;
  bit finished = 1'b0;

  railseq_top #(.CODE_W(CODE_W), .TIME_W(TIME_W), .INIT_TICKS(INIT)) u0 (
    .clk(clk), .rst(rst), .tick(tick), .en(en),
    .dly_ticks(dly_ticks), .ramp_ticks(ramp_ticks), .hiccup_ticks(hiccup_ticks),
    .target_code(target_code), .ov_thr(ov_thr), .uv_thr(uv_thr), .vsample(vsample),
    .ov_en(ov_en), .uv_en(uv_en), .ov_retry(ov_retry), .uv_retry(uv_retry),
    .rail_on(rail_on), .vref(vref), .pgood(pgood), .alert(alert),
    .lsd_pulse(lsd_pulse), .ov_flag(ov_flag), .uv_flag(uv_flag)
  );

  always #2.5 clk = ~clk;

  initial begin
    int ph = 0;
    forever begin
      @(negedge clk);
      ph = (ph == TICKP - 1) ? 0 : ph + 1;
      tick = (ph == 0);
    end
  end

  always @(posedge clk) if (tick) tcount <= tcount + 1;

  // dly, ramp, target, mid tick, vref at mid tick, expected wait ticks
  typedef struct packed {
    logic [15:0] dly;
    logic [15:0] rlen;
    logic [11:0] tgt;
    logic [15:0] mk;
    logic [11:0] mv;
    logic [15:0] wt;
  } vec_t;
  localparam vec_t VECS [0:3] = '{
    '{16'd3,  16'd5, 12'd1000, 16'd2, 12'd400,  16'd10},
    '{16'd15, 16'd7, 12'd1000, 16'd3, 12'd428,  16'd15},
    '{16'd0,  16'd0, 12'd2000, 16'd0, 12'd2000, 16'd10},
    '{16'd10, 16'd3, 12'd7,    16'd1, 12'd2,    16'd10}
  };

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic align();
    do @(posedge clk); while (!tick);
    @(negedge clk);
  endtask

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      do @(posedge clk); while (!tick);
    end
    @(negedge clk);
  endtask

  task automatic wait_rail(input bit lvl, input int t0, output int nt);
    int guard = 0;
    while (rail_on !== lvl && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    nt = tcount - t0;
  endtask

  task automatic start_rail(output int nt);
    int t0;
    align();
    t0 = tcount;
    en = 1'b1;
    wait_rail(1'b1, t0, nt);
  endtask

  task automatic to_reg();
    int nt;
    start_rail(nt);
    wait_ticks(int'(ramp_ticks));
    repeat (4) @(negedge clk);
  endtask

  task automatic stop_rail();
    en = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int nt, t0, rises;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!rail_on && !pgood && !alert && !lsd_pulse && !ov_flag && !uv_flag, "R1 reset outputs",
        {rail_on, pgood, alert, lsd_pulse, ov_flag, uv_flag}, 0);
    chk(vref == 0, "R1 reset vref", vref, 0);

    // Vector table: wait time (R2), ramp shape (R3), power good (R4), disable (R1)
    foreach (VECS[i]) begin
      dly_ticks   = VECS[i].dly;
      ramp_ticks  = VECS[i].rlen;
      target_code = VECS[i].tgt;
      start_rail(nt);
      chk(nt == int'(VECS[i].wt), $sformatf("R2 wait ticks vec%0d", i), nt, VECS[i].wt);
      chk(!pgood, $sformatf("R4 pgood low at ramp start vec%0d", i), pgood, 0);
      if (VECS[i].mk != 0) wait_ticks(int'(VECS[i].mk));
      chk(vref == VECS[i].mv, $sformatf("R3 vref mid vec%0d", i), vref, VECS[i].mv);
      if (VECS[i].rlen > VECS[i].mk) wait_ticks(int'(VECS[i].rlen - VECS[i].mk));
      chk(vref == VECS[i].tgt, $sformatf("R3 vref final vec%0d", i), vref, VECS[i].tgt);
      repeat (4) @(negedge clk);
      chk(pgood == 1'b1, $sformatf("R4 pgood in regulation vec%0d", i), pgood, 1);
      en = 1'b0;
      @(negedge clk);
      chk(!rail_on && !pgood && vref == 0, $sformatf("R1 disable vec%0d", i), {rail_on, pgood}, 0);
      repeat (3) @(negedge clk);
    end

    dly_ticks = 16'd3; ramp_ticks = 16'd4; target_code = 12'd1000;

    // R5 over-voltage with latch (R8)
    ov_retry = 1'b0;
    to_reg();
    align();
    vsample = 12'd3500;
    repeat (3) @(negedge clk);
    chk(!rail_on && !pgood && vref == 0, "R5 ov shuts rail", {rail_on, pgood}, 0);
    chk(ov_flag && alert && !uv_flag, "R5 ov flag and alert", {ov_flag, alert, uv_flag}, 6);
    rises = 0;
    for (int i = 0; i < 6; i++) begin
      bit prev = lsd_pulse;
      wait_ticks(1);
      if (lsd_pulse && !prev) rises++;
    end
    chk(rises >= 2, "R5 lsd toggles", rises, 3);
    vsample = 12'd1000;
    repeat (3) @(negedge clk);
    chk(!lsd_pulse, "R5 lsd stops", lsd_pulse, 0);
    wait_ticks(20);
    chk(!rail_on, "R8 latched off", rail_on, 0);
    chk(ov_flag && alert, "R10 flags held", {ov_flag, alert}, 3);
    stop_rail();
    chk(!alert && !ov_flag, "R10 flags cleared", {alert, ov_flag}, 0);
    start_rail(nt);
    chk(nt == INIT, "R8 restart after enable cycle", nt, INIT);
    stop_rail();

    // R6 under-voltage with retry (R9)
    uv_retry = 1'b1;
    to_reg();
    align();
    t0 = tcount;
    vsample = 12'd100;
    repeat (3) @(negedge clk);
    chk(!rail_on && !pgood, "R6 uv shuts rail", {rail_on, pgood}, 0);
    chk(uv_flag && alert && !ov_flag && !lsd_pulse, "R6 uv flags no lsd",
        {uv_flag, alert, ov_flag, lsd_pulse}, 12);
    vsample = 12'd1000;
    wait_rail(1'b1, t0, nt);
    chk(nt == 9, "R9 retry restart ticks", nt, 9);
    chk(uv_flag && alert, "R9 flags kept on retry", {uv_flag, alert}, 3);
    stop_rail();
    uv_retry = 1'b0;

    // R7 disabled faults
    uv_en = 1'b0; ov_en = 1'b0;
    to_reg();
    vsample = 12'd100;
    repeat (5) @(negedge clk);
    chk(rail_on && !pgood && !alert && !uv_flag, "R7 uv disabled",
        {rail_on, pgood, alert, uv_flag}, 8);
    vsample = 12'd3500;
    repeat (5) @(negedge clk);
    chk(rail_on && !pgood && !ov_flag && !lsd_pulse, "R7 ov disabled",
        {rail_on, pgood, ov_flag, lsd_pulse}, 8);
    vsample = 12'd1000;
    repeat (3) @(negedge clk);
    chk(pgood, "R7 pgood back in window", pgood, 1);
    stop_rail();
    uv_en = 1'b1; ov_en = 1'b1;

    // R1 enable dropped mid-ramp
    ramp_ticks = 16'd10;
    start_rail(nt);
    wait_ticks(4);
    chk(vref == 400, "R3 vref mid long ramp", vref, 400);
    en = 1'b0;
    @(negedge clk);
    chk(!rail_on && vref == 0, "R1 drop mid-ramp", {rail_on, vref}, 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule